// File: doc/BRIEF.md
# Floating-Point Status Exception Recorder

This block keeps the 32-bit floating-point status and control word of an execution pipe. After each floating-point operation, the pipe hands it a vector of the exception events that the operation raised. The recorder folds that vector into sticky cause bits. It then rebuilds two summary bits from the complete sticky state: the invalid-operation summary and the enabled-exception summary. In the cycle after the update it reports whether the new enabled-exception summary requests a trap.

An update can also carry a record flag. When the flag is set, the recorder returns a copy of the condition register in which field 1 is replaced by the four most significant status bits. The status word can also be loaded through a direct write port. A direct write wins over an update in the same cycle. In that case the update is back-pressured: `upd_ready` is low while `wr_en` is high. The producer must keep `upd_valid`, the events, the record flag and `cr_in` stable until a cycle in which `upd_valid` and `upd_ready` are both high. Only such a cycle counts as a transfer.

Top module: `fp_status_recorder`

## Requirements
- R1: While reset is active and after it is released, `status_o`, `cr_o`, `done_o` and `trap_o` are all zero.
- R2: Event index to sticky status bit: 0 overflow to bit 28, 1 underflow to bit 27, 2 divide-by-zero to bit 26, 3 inexact to bit 25. Invalid causes 4..9 go to bits 24 down to 19: signalling NaN, inf-inf, inf/inf, 0/0, inf*0, invalid compare. Events 10, 11 and 12 go to bits 10, 9 and 8: software request, invalid square root, invalid integer convert. Any raised event also sets bit 31. An update never clears any of these bits.
- R3: An update leaves every status bit unchanged that is neither sticky nor bit 29 or bit 30. This includes the enables at bits 7..3.
- R4: Every transfer rewrites bit 29 (invalid summary) as the OR of the nine invalid-cause bits after merging. This holds even when no event is raised, so a stale summary is cleared.
- R5: Every transfer rewrites bit 30 (enabled summary) as the OR of five pairs, each taken after merging. The pairs are bit29&bit7, bit28&bit6, bit27&bit5, bit26&bit4 and bit25&bit3.
- R6: `done_o` is high for exactly one cycle after each transfer. In that cycle `trap_o` equals the new bit 30. At all other times `trap_o` is low.
- R7: On a transfer, `cr_o` takes the value of `cr_in`. If the record flag is set, `cr_o[27:24]` is replaced by the new `status_o[31:28]`. Between transfers `cr_o` holds.
- R8: `upd_ready` is the inverse of `wr_en`. A direct write loads `wr_data` into the status on the next edge, and an update that is presented in the same cycle is not taken.
- R9: While no transfer and no write occurs, the status is unchanged and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct status write strobe |
| wr_data | input | 32 | Value loaded by a direct write |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Update may be taken this cycle |
| upd_events | input | 13 | Raised exception events |
| upd_record | input | 1 | Copy status top nibble into condition field 1 |
| cr_in | input | 32 | Condition register value travelling with the update |
| status_o | output | 32 | Current status and control word |
| done_o | output | 1 | One-cycle pulse after a transfer |
| trap_o | output | 1 | Trap request, qualified by done_o |
| cr_o | output | 32 | Condition register result of the last transfer |

## Verification
The direct write and an offered update can arrive in the same cycle. The random stream provokes this by raising `wr_en` on top of a pending update about one time in five. In such a cycle the bench checks that `upd_ready` is low and that the status afterwards equals the written value with `done_o` low. It then keeps the same update offered and checks that the update is applied to the freshly written word in the following cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W = 32;
  localparam int EV_W   = 13;
  localparam int NPAIR  = 5;

  localparam int B_FX   = 31;
  localparam int B_FEX  = 30;
  localparam int B_VX   = 29;
  localparam int B_OX   = 28;
  localparam int B_UX   = 27;
  localparam int B_ZX   = 26;
  localparam int B_XX   = 25;
  localparam int B_VE   = 7;
  localparam int B_OE   = 6;
  localparam int B_UE   = 5;
  localparam int B_ZE   = 4;
  localparam int B_XE   = 3;

  localparam logic [STAT_W-1:0] INV_MASK    = 32'h01F8_0700;
  localparam logic [STAT_W-1:0] STICKY_MASK = 32'h9FF8_0700;
  localparam logic [STAT_W-1:0] KEEP_MASK   = 32'h0007_F8FF;

  // status bit that event i sets
  function automatic int unsigned ev_bit(input int unsigned i);
    case (i)
      0:  return 28;
      1:  return 27;
      2:  return 26;
      3:  return 25;
      4:  return 24;
      5:  return 23;
      6:  return 22;
      7:  return 21;
      8:  return 20;
      9:  return 19;
      10: return 10;
      11: return 9;
      default: return 8;
    endcase
  endfunction

  // cause side of enable pair k
  function automatic int unsigned pair_cause(input int unsigned k);
    case (k)
      0: return B_VX;
      1: return B_OX;
      2: return B_UX;
      3: return B_ZX;
      default: return B_XX;
    endcase
  endfunction

  // enable side of enable pair k
  function automatic int unsigned pair_enable(input int unsigned k);
    case (k)
      0: return B_VE;
      1: return B_OE;
      2: return B_UE;
      3: return B_ZE;
      default: return B_XE;
    endcase
  endfunction
endpackage

// File: rtl/fsr_sticky_merge.sv
module fsr_sticky_merge
  import fsr_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int EW = EV_W
) (
  input  logic [W-1:0]  stat_i,
  input  logic [EW-1:0] ev_i,
  output logic [W-1:0]  stat_o
);
  logic [W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < EW; i++) begin
      set_vec[ev_bit(i)] = set_vec[ev_bit(i)] | ev_i[i];
    end
    set_vec[B_FX] = set_vec[B_FX] | (|ev_i);
  end

  assign stat_o = stat_i | set_vec;
endmodule

// File: rtl/fsr_summary.sv
module fsr_summary
  import fsr_pkg::*;
#(
  parameter int W = STAT_W,
  parameter int NP = NPAIR
) (
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] stat_o
);
  logic          vx_new;
  logic [W-1:0]  with_vx;
  logic [NP-1:0] pair_hit;

  assign vx_new = |(stat_i & INV_MASK);

  always_comb begin
    with_vx        = stat_i;
    with_vx[B_VX]  = vx_new;
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    localparam int unsigned CP = pair_cause(k);
    localparam int unsigned EP = pair_enable(k);
    assign pair_hit[k] = with_vx[CP] & with_vx[EP];
  end

  always_comb begin
    stat_o         = with_vx;
    stat_o[B_FEX]  = |pair_hit;
  end
endmodule

// File: rtl/fsr_cr_merge.sv
module fsr_cr_merge #(
  parameter int CR_W  = 32,
  parameter int FIELD = 1
) (
  input  logic [CR_W-1:0] cr_i,
  input  logic [3:0]      nib_i,
  input  logic            rec_i,
  output logic [CR_W-1:0] cr_o
);
  localparam int HI = CR_W - 1 - 4 * FIELD;

  always_comb begin
    cr_o = cr_i;
    if (rec_i) cr_o[HI -: 4] = nib_i;
  end
endmodule

// File: rtl/fp_status_recorder.sv
module fp_status_recorder
  import fsr_pkg::*;
#(
  parameter int CR_W  = 32,
  parameter int FIELD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [EV_W-1:0]   upd_events,
  input  logic              upd_record,
  input  logic [CR_W-1:0]   cr_in,
  output logic [STAT_W-1:0] status_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [CR_W-1:0]   cr_o
);
  logic [STAT_W-1:0] stat_q, merged, next_stat;
  logic [CR_W-1:0]   cr_q, cr_next;
  logic              done_q, trap_q, take;

  assign upd_ready = ~wr_en;
  assign take      = upd_valid & upd_ready;

  fsr_sticky_merge #(.W(STAT_W), .EW(EV_W)) u_merge (
    .stat_i (stat_q),
    .ev_i   (upd_events),
    .stat_o (merged)
  );

  fsr_summary #(.W(STAT_W), .NP(NPAIR)) u_sum (
    .stat_i (merged),
    .stat_o (next_stat)
  );

  fsr_cr_merge #(.CR_W(CR_W), .FIELD(FIELD)) u_cr (
    .cr_i  (cr_in),
    .nib_i (next_stat[STAT_W-1 -: 4]),
    .rec_i (upd_record),
    .cr_o  (cr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      cr_q   <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      done_q <= take;
      trap_q <= take & next_stat[B_FEX];
      if (wr_en) begin
        stat_q <= wr_data;
      end else if (take) begin
        stat_q <= next_stat;
        cr_q   <= cr_next;
      end
    end
  end

  assign status_o = stat_q;
  assign done_o   = done_q;
  assign trap_o   = trap_q;
  assign cr_o     = cr_q;
endmodule

// File: rtl/fp_status_recorder_chk.sv
module fp_status_recorder_chk
  import fsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [EV_W-1:0]   upd_events,
  input logic              upd_record,
  input logic [31:0]       cr_in,
  input logic [STAT_W-1:0] status_o,
  input logic              done_o,
  input logic              trap_o,
  input logic [31:0]       cr_o
);
  // R2: any event sets bit 31
  a_r2_fx_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && (|upd_events)) |=> status_o[B_FX]);

  // R2: sticky bits survive an update
  a_r2_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=>
      ((status_o & $past(status_o) & STICKY_MASK) == ($past(status_o) & STICKY_MASK)));

  // R3: control bits untouched by update
  a_r3_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> ((status_o & KEEP_MASK) == ($past(status_o) & KEEP_MASK)));

  // R4: invalid summary consistent after transfer
  a_r4_vx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o[B_VX] == (|(status_o & INV_MASK))));

  // R5: enabled summary consistent after transfer
  a_r5_fex_summary: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o[B_FEX] == ((status_o[B_VX] & status_o[B_VE]) |
                                     (status_o[B_OX] & status_o[B_OE]) |
                                     (status_o[B_UX] & status_o[B_UE]) |
                                     (status_o[B_ZX] & status_o[B_ZE]) |
                                     (status_o[B_XX] & status_o[B_XE]))));

  // R6: trap only with done, equal to new summary
  a_r6_trap_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> done_o);
  a_r6_trap_value: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (trap_o == status_o[B_FEX]));

  // R7: recorded nibble lands in field 1
  a_r7_cr_field: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_record) |=> (cr_o[27:24] == status_o[31:28]));

  // R8: ready drops during a write, write lands
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !upd_ready);
  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_o == $past(wr_data)) && !done_o);

  // R9: idle keeps the status
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_valid) |=> ($stable(status_o) && !done_o));
endmodule

bind fp_status_recorder fp_status_recorder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .upd_valid  (upd_valid),
  .upd_ready  (upd_ready),
  .upd_events (upd_events),
  .upd_record (upd_record),
  .cr_in      (cr_in),
  .status_o   (status_o),
  .done_o     (done_o),
  .trap_o     (trap_o),
  .cr_o       (cr_o)
);

// File: tb/fp_status_recorder_bench.sv
module fp_status_recorder_bench;
  localparam int CLK_P = 10;
  localparam int N_RAND = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [12:0] upd_events = '0;
  logic        upd_record = 1'b0;
  logic [31:0] cr_in = '0;
  logic [31:0] status_o;
  logic        done_o, trap_o;
  logic [31:0] cr_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] e_stat = '0;
  logic [31:0] e_cr = '0;
  logic        e_done = 1'b0;
  logic        e_trap = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fp_status_recorder u_fp_status_recorder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_events(upd_events),
    .upd_record(upd_record), .cr_in(cr_in), .status_o(status_o),
    .done_o(done_o), .trap_o(trap_o), .cr_o(cr_o)
  );

  // expected next status from the requirements
  function automatic logic [31:0] ref_next(input logic [31:0] s, input logic [12:0] ev);
    logic [31:0] n;
    logic vx, fx;
    n = s;
    if (ev != 0) n[31] = 1'b1;
    n[28] |= ev[0];
    n[27] |= ev[1];
    n[26] |= ev[2];
    n[25] |= ev[3];
    for (int i = 0; i < 6; i++) n[24-i] |= ev[4+i];
    n[10] |= ev[10];
    n[9]  |= ev[11];
    n[8]  |= ev[12];
    vx = (|n[24:19]) | (|n[10:8]);
    n[29] = vx;
    fx = (vx & n[7]) | (n[28] & n[6]) | (n[27] & n[5]) | (n[26] & n[4]) | (n[25] & n[3]);
    n[30] = fx;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(input logic wr, input logic [31:0] wd, input logic v,
                      input logic [12:0] ev, input logic rec, input logic [31:0] cr);
    logic [31:0] n;
    string tag;
    wr_en = wr; wr_data = wd; upd_valid = v; upd_events = ev;
    upd_record = rec; cr_in = cr;
    #1;
    chk("R8 ready", {31'd0, upd_ready}, {31'd0, ~wr});
    if (wr) begin
      e_stat = wd; e_done = 1'b0; e_trap = 1'b0; tag = "R8 write";
    end else if (v) begin
      n = ref_next(e_stat, ev);
      e_stat = n; e_done = 1'b1; e_trap = n[30];
      e_cr = cr;
      if (rec) e_cr[27:24] = n[31:28];
      tag = "R2 update";
    end else begin
      e_done = 1'b0; e_trap = 1'b0; tag = "R9 idle";
    end
    @(negedge clk);
    chk(tag, status_o, e_stat);
    chk("R6 done", {31'd0, done_o}, {31'd0, e_done});
    chk("R6 trap", {31'd0, trap_o}, {31'd0, e_trap});
    chk("R7 cr", cr_o, e_cr);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 status", status_o, 32'h0);
    chk("R1 cr", cr_o, 32'h0);
    chk("R1 flags", {30'd0, done_o, trap_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", status_o, 32'h0);

    // R4: stale VX with no causes is cleared by an empty update
    step(1'b1, 32'h2000_0080, 1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, '0, 1'b0, 32'h1234_5678);
    chk("R4 vx cleared", {31'd0, status_o[29]}, 32'h0);
    chk("R3 enable kept", {31'd0, status_o[7]}, 32'h1);

    // R2: FX is sticky through an empty update
    step(1'b1, 32'h8000_0000, 1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, '0, 1'b1, 32'hFFFF_FFFF);
    chk("R2 fx sticky", {31'd0, status_o[31]}, 32'h1);
    chk("R7 field1 nibble", {28'd0, cr_o[27:24]}, 32'h8);

    // R5: overflow with its enable traps
    step(1'b1, 32'h0000_0040, 1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, 13'h0001, 1'b1, 32'h0);
    chk("R5 fex set", {31'd0, status_o[30]}, 32'h1);
    chk("R6 trap raised", {31'd0, trap_o}, 32'h1);
    // R5: invalid-convert with VE traps through VX
    step(1'b1, 32'h0000_0080, 1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, 13'h1000, 1'b0, 32'h0);
    chk("R5 vx path", status_o, 32'hE000_0180);
    // R9: idle cycle
    step(1'b0, '0, 1'b0, 13'h1FFF, 1'b1, 32'hDEAD_BEEF);

    // R8: collision then held update
    step(1'b1, 32'h0000_0020, 1'b1, 13'h0002, 1'b1, 32'hA5A5_A5A5);
    step(1'b0, '0, 1'b1, 13'h0002, 1'b1, 32'hA5A5_A5A5);
    chk("R8 held update", status_o, 32'hC800_0020);

    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      logic [12:0] ev;
      logic [31:0] cr, wd;
      logic v, rec, wr;
      int r;
      r = $urandom_range(0, 99);
      ev = ($urandom_range(0, 3) == 0) ? 13'h0 : (13'($urandom) & 13'($urandom));
      cr = $urandom; wd = $urandom; rec = 1'($urandom);
      v = (r < 80);
      wr = (r >= 90) || (v && r < 16);
      if ($urandom_range(0, 3) == 0) wd = wd & 32'h0000_00F8;
      step(wr, wd, v, ev, rec, cr);
      if (wr && v) step(1'b0, '0, 1'b1, ev, rec, cr);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule